// File: doc/BRIEF.md
# Three-Operand Pipelined Adder with Operand Alignment

This block adds three unsigned operands, q = a + b + c, with a chain of two two-input adders. The first adder forms a partial sum p = a + b; the second adds p to c. Each adder has its own compile-time number of pipeline register stages, from none up to five. That lets the block be fitted to a clock target without touching the surrounding logic.

Operand c skips the first adder. It passes through a delay line as deep as that adder, so it reaches the second adder in the same cycle as the partial sum it belongs to. The delay is derived from the adder depth parameter, so alignment holds at every depth setting.

A valid bit travels with every operand set. The block takes a new set on every clock. The result leaves with its own valid bit after the sum of both adder depths.

Top module: `sum3_aligned`

## Requirements
- R1: When outValid is high, q equals a + b + c of the operand set that was presented with inValid high exactly DEPTH_P + DEPTH_Q cycles earlier.
- R2: outValid is high in a cycle if and only if inValid was high exactly DEPTH_P + DEPTH_Q cycles earlier (with no reset in between). Gaps in inValid reappear at the output in the same positions.
- R3: DEPTH_P and DEPTH_Q each accept 0 to 5 register stages and default to 1, which gives a latency of 2. With both set to 0 the result and its valid follow the inputs in the same cycle.
- R4: A new operand set may be presented on every cycle. Back-to-back sets each produce their own correct sum, because c is delayed by exactly DEPTH_P cycles to meet its partial sum.
- R5: outValid pulses exactly once for every cycle in which inValid was accepted.
- R6: A synchronous active-high reset (rst) clears every valid bit in the pipeline. Operand sets in flight at reset never produce an outValid pulse, and outValid is low in the cycle after reset.
- R7: All additions wrap modulo 2^WIDTH and no carry is kept; for example, with WIDTH = 8, 0xFF + 0xFF + 0xFF gives 0xFD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid bits |
| inValid | input | 1 | Operand set on a, b, c is valid this cycle |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| c | input | WIDTH | Third operand, bypasses the first adder |
| outValid | output | 1 | q carries a result this cycle |
| q | output | WIDTH | Sum a + b + c modulo 2^WIDTH |

## Verification
The bench builds five copies at an 8-bit width with depth pairs (1,1), (0,0), (2,3), (5,5) and (0,4), plus one copy left at its default depths. The 8-bit width puts wraparound within easy reach of hand-picked operands. The fully combinational pair exposes same-cycle behaviour. The (0,4) pair has no delay on c at all but a deep second stage. The (5,5) pair holds ten sets in flight, which tests back-to-back alignment and reset with the deepest pipeline.

// File: rtl/sum3_pkg.sv
package sum3_pkg;

  // Upper bound on register stages per adder
  localparam int MaxStages = 5;

  typedef logic [MaxStages-1:0] stageMask_t;

  // Per-stage load strobes issued by the control to the datapath
  typedef struct packed {
    stageMask_t firstLoad;   // stages of the a+b adder and the c delay line
    stageMask_t secondLoad;  // stages of the p+c adder
  } stageStrobes_t;

endpackage

// File: rtl/sum3_stageline.sv
// Chain of STAGES registers; stage k captures only when loadEn[k] is high.
module sum3_stageline
  import sum3_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int STAGES = 1
) (
  input  logic             clk,
  input  stageMask_t       loadEn,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  // Bits above STAGES are not needed by this instance
  logic unusedLoad;
  assign unusedLoad = ^loadEn;

  if (STAGES == 0) begin : gPass
    assign dOut = dIn;
  end else begin : gRegs
    logic [WIDTH-1:0] held [STAGES];

    always_ff @(posedge clk) begin
      if (loadEn[0]) held[0] <= dIn;
      for (int k = 1; k < STAGES; k++) begin
        if (loadEn[k]) held[k] <= held[k-1];
      end
    end

    assign dOut = held[STAGES-1];
  end

endmodule

// File: rtl/sum3_ctrl.sv
// Valid chain for both adders; converts it into per-stage load strobes.
module sum3_ctrl
  import sum3_pkg::*;
#(
  parameter int DEPTH_P = 1,
  parameter int DEPTH_Q = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  output stageStrobes_t strobes,
  output logic          outValid
);

  localparam int Total = DEPTH_P + DEPTH_Q;

  // vAt[k] is the valid bit presented to overall stage k
  logic [Total:0] vAt;

  if (Total == 0) begin : gNoRegs
    assign vAt = inValid;
  end else begin : gChain
    logic [Total-1:0] vReg;

    always_ff @(posedge clk) begin
      if (rst) vReg <= '0;
      else     vReg <= vAt[Total-1:0];
    end

    assign vAt = {vReg, inValid};
  end

  always_comb begin
    strobes = '0;
    for (int k = 0; k < DEPTH_P; k++) strobes.firstLoad[k]  = vAt[k];
    for (int k = 0; k < DEPTH_Q; k++) strobes.secondLoad[k] = vAt[DEPTH_P + k];
  end

  assign outValid = vAt[Total];

endmodule

// File: rtl/sum3_datapath.sv
// Two chained adders plus the bypass delay that keeps c in step with a+b.
module sum3_datapath
  import sum3_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int DEPTH_P = 1,
  parameter int DEPTH_Q = 1
) (
  input  logic             clk,
  input  stageStrobes_t    strobes,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] c,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] partialNow;
  logic [WIDTH-1:0] partial;
  logic [WIDTH-1:0] cAligned;
  logic [WIDTH-1:0] finalNow;

  // First adder: wraps modulo 2^WIDTH
  assign partialNow = a + b;

  sum3_stageline #(.WIDTH(WIDTH), .STAGES(DEPTH_P)) uFirstAdd (
    .clk    (clk),
    .loadEn (strobes.firstLoad),
    .dIn    (partialNow),
    .dOut   (partial)
  );

  // Bypass delay: same depth and same strobes as the first adder
  sum3_stageline #(.WIDTH(WIDTH), .STAGES(DEPTH_P)) uBypass (
    .clk    (clk),
    .loadEn (strobes.firstLoad),
    .dIn    (c),
    .dOut   (cAligned)
  );

  // Second adder
  assign finalNow = partial + cAligned;

  sum3_stageline #(.WIDTH(WIDTH), .STAGES(DEPTH_Q)) uSecondAdd (
    .clk    (clk),
    .loadEn (strobes.secondLoad),
    .dIn    (finalNow),
    .dOut   (q)
  );

endmodule

// File: rtl/sum3_aligned.sv
module sum3_aligned
  import sum3_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int DEPTH_P = 1,
  parameter int DEPTH_Q = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] c,
  output logic             outValid,
  output logic [WIDTH-1:0] q
);

  if (DEPTH_P < 0 || DEPTH_P > MaxStages || DEPTH_Q < 0 || DEPTH_Q > MaxStages)
  begin : gBadDepth
    $error("sum3_aligned: adder depth outside 0..%0d", MaxStages);
  end

  stageStrobes_t strobes;

  sum3_ctrl #(.DEPTH_P(DEPTH_P), .DEPTH_Q(DEPTH_Q)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  sum3_datapath #(.WIDTH(WIDTH), .DEPTH_P(DEPTH_P), .DEPTH_Q(DEPTH_Q)) uData (
    .clk     (clk),
    .strobes (strobes),
    .a       (a),
    .b       (b),
    .c       (c),
    .q       (q)
  );

endmodule

// File: rtl/sum3_aligned_chk.sv
module sum3_aligned_chk #(
  parameter int WIDTH   = 16,
  parameter int DEPTH_P = 1,
  parameter int DEPTH_Q = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [WIDTH-1:0] c,
  input logic             outValid,
  input logic [WIDTH-1:0] q
);

  localparam int Total = DEPTH_P + DEPTH_Q;
  localparam int CntW  = $clog2(Total + 2);

  logic [WIDTH-1:0] sumIn;
  assign sumIn = a + b + c;

  if (Total == 0) begin : gComb
    always @(posedge clk) begin
      if (!rst) begin
        // R3: zero depth gives the result in the same cycle
        assert_comb_sum_R3: assert (!outValid || q == sumIn);
        assert_comb_valid_R2: assert (outValid == inValid);
      end
    end
  end else begin : gSeq
    // Cycles since reset, saturating at Total
    logic [CntW-1:0] sinceRst;

    always_ff @(posedge clk) begin
      if (rst)                           sinceRst <= '0;
      else if (sinceRst != CntW'(Total)) sinceRst <= sinceRst + 1'b1;
    end

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
      (sinceRst >= CntW'(Total)) |-> (outValid == $past(inValid, Total)));

    assert_sum_match_R1: assert property (@(posedge clk) disable iff (rst)
      ((sinceRst >= CntW'(Total)) && outValid) |-> (q == $past(sumIn, Total)));

    assert_reset_clears_R6: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> !outValid);
  end

endmodule

bind sum3_aligned sum3_aligned_chk #(
  .WIDTH(WIDTH), .DEPTH_P(DEPTH_P), .DEPTH_Q(DEPTH_Q)
) uChk (.*);

// File: tb/sum3_aligned_test.sv
module sum3_aligned_test;

  localparam int Period  = 10;
  localparam int W       = 8;
  localparam int NumCfg  = 5;
  localparam int HistLen = 16;
  localparam int CfgP [NumCfg] = '{1, 0, 2, 5, 0};
  localparam int CfgQ [NumCfg] = '{1, 0, 3, 5, 4};
  localparam int DefLat = 2;  // default depths 1 + 1

  // {valid, a, b, c}; includes wrap cases (R7) and bubbles (R2)
  localparam logic [3*W:0] Vecs [16] = '{
    {1'b1, 8'h01, 8'h02, 8'h03}, {1'b1, 8'hFF, 8'h01, 8'h00},
    {1'b1, 8'hFF, 8'hFF, 8'hFF}, {1'b0, 8'h55, 8'h55, 8'h55},
    {1'b1, 8'h00, 8'h00, 8'h00}, {1'b1, 8'h80, 8'h80, 8'h01},
    {1'b0, 8'h12, 8'h34, 8'h56}, {1'b0, 8'hAA, 8'hBB, 8'hCC},
    {1'b1, 8'h10, 8'h20, 8'h30}, {1'b1, 8'h7F, 8'h01, 8'h80},
    {1'b1, 8'h00, 8'hFF, 8'h01}, {1'b0, 8'hFF, 8'hFF, 8'hFF},
    {1'b1, 8'h3C, 8'hC3, 8'h11}, {1'b1, 8'h01, 8'h00, 8'hFF},
    {1'b1, 8'hDE, 8'hAD, 8'hBE}, {1'b1, 8'h00, 8'h00, 8'hFF}
  };

  logic clk = 1'b0;
  always #(Period/2) clk = ~clk;

  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [W-1:0] a = '0, b = '0, c = '0;

  logic         outValid [NumCfg];
  logic [W-1:0] q [NumCfg];
  logic         defValid;
  logic [W-1:0] defQ;

  for (genvar g = 0; g < NumCfg; g++) begin : cfg
    sum3_aligned #(.WIDTH(W), .DEPTH_P(CfgP[g]), .DEPTH_Q(CfgQ[g])) uut (
      .clk(clk), .rst(rst), .inValid(inValid), .a(a), .b(b), .c(c),
      .outValid(outValid[g]), .q(q[g])
    );
  end

  sum3_aligned #(.WIDTH(W)) uutDefault (
    .clk(clk), .rst(rst), .inValid(inValid), .a(a), .b(b), .c(c),
    .outValid(defValid), .q(defQ)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int outCnt [NumCfg];
  int defCnt = 0;
  logic         histValid [HistLen];
  logic [W-1:0] histSum [HistLen];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // One cycle: drive at the falling edge, sample a quarter period later.
  task automatic step(input logic v, input logic [W-1:0] ia, input logic [W-1:0] ib,
                      input logic [W-1:0] ic, input logic r, input string tag);
    logic [W-1:0] s;
    int idx;
    @(negedge clk);
    rst = r; inValid = v && !r; a = ia; b = ib; c = ic;
    s = ia + ib + ic;
    idx = cyc % HistLen;
    histValid[idx] = v && !r;
    histSum[idx]   = s;
    #(Period/4);
    for (int g = 0; g < NumCfg; g++) begin
      int lat;
      logic expV;
      lat  = CfgP[g] + CfgQ[g];
      expV = (cyc >= lat) ? histValid[(cyc - lat) % HistLen] : 1'b0;
      check(outValid[g] === expV, "R2 valid timing", 32'(outValid[g]), 32'(expV));
      if (expV)
        check(q[g] === histSum[(cyc - lat) % HistLen], tag, 32'(q[g]),
              32'(histSum[(cyc - lat) % HistLen]));
      if (outValid[g] === 1'b1) outCnt[g]++;
    end
    begin
      logic dExp;
      dExp = (cyc >= DefLat) ? histValid[(cyc - DefLat) % HistLen] : 1'b0;
      check(defValid === dExp, "R3 default depth latency", 32'(defValid), 32'(dExp));
      if (dExp)
        check(defQ === histSum[(cyc - DefLat) % HistLen], "R3 default depth sum",
              32'(defQ), 32'(histSum[(cyc - DefLat) % HistLen]));
      if (defValid === 1'b1) defCnt++;
    end
    if (r) for (int i = 0; i < HistLen; i++) histValid[i] = 1'b0;
    cyc++;
  endtask

  task automatic clearCounts();
    for (int g = 0; g < NumCfg; g++) outCnt[g] = 0;
    defCnt = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0, 1'b0, tag);
  endtask

  initial begin
    for (int i = 0; i < HistLen; i++) begin histValid[i] = 1'b0; histSum[i] = '0; end
    clearCounts();

    // R6: reset state
    for (int i = 0; i < 3; i++) step(1'b0, '0, '0, '0, 1'b1, "R6");
    step(1'b0, '0, '0, '0, 1'b0, "R6");
    for (int g = 0; g < NumCfg; g++)
      check(outValid[g] === 1'b0, "R6 valid low after reset", 32'(outValid[g]), 0);

    // Table walk: sums (R1), wrap (R7), bubbles (R2)
    for (int i = 0; i < 16; i++) begin
      step(Vecs[i][3*W], Vecs[i][3*W-1:2*W], Vecs[i][2*W-1:W], Vecs[i][W-1:0],
           1'b0, "R1 sum");
      if (i == 2) begin
        // R7: 0xFF*3 wraps to 0xFD; R3: zero-depth copy shows it this cycle
        check(q[1] === 8'hFD, "R7 wrap", 32'(q[1]), 32'h0FD);
        check(outValid[1] === 1'b1, "R3 zero depth same cycle", 32'(outValid[1]), 1);
      end
    end
    idle(12, "R1 drain");

    // R4/R5: back-to-back random sets
    clearCounts();
    for (int i = 0; i < 60; i++)
      step(1'b1, W'($urandom), W'($urandom), W'($urandom), 1'b0, "R4 back-to-back");
    idle(12, "R4 drain");
    for (int g = 0; g < NumCfg; g++)
      check(outCnt[g] == 60, "R5 one pulse per input", 32'(outCnt[g]), 60);
    check(defCnt == 60, "R5 one pulse per input (default)", 32'(defCnt), 60);

    // R6: reset with sets in flight
    for (int i = 0; i < 5; i++)
      step(1'b1, W'($urandom), W'($urandom), W'($urandom), 1'b0, "R6 preload");
    step(1'b0, '0, '0, '0, 1'b1, "R6");
    clearCounts();
    idle(12, "R6 flush");
    for (int g = 0; g < NumCfg; g++)
      check(outCnt[g] == 0, "R6 in-flight sets dropped", 32'(outCnt[g]), 0);
    check(defCnt == 0, "R6 in-flight sets dropped (default)", 32'(defCnt), 0);

    // Alternating valid pattern after reset (R2 gap positions)
    clearCounts();
    for (int i = 0; i < 20; i++)
      step(i[0], W'($urandom), W'($urandom), W'($urandom), 1'b0, "R1 alternating");
    idle(12, "R2 drain");
    for (int g = 0; g < NumCfg; g++)
      check(outCnt[g] == 10, "R5 pulses with gaps", 32'(outCnt[g]), 10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(Period * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog (R1..): actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule